// File: doc/BRIEF.md
# Radio Configuration Register Bank

This block holds the four 22-bit control words that steer a radio transceiver's control logic. It has two modes. After reset it is in stand-alone mode. Two strap pins then pick one of four built-in divider presets, and two mode pins pick the operating state directly. The strap pin that doubles as the serial enable is watched. Its first change of level moves the block into programmable mode, and it never returns.

In programmable mode a three-wire serial port writes the words. The three wires are a clock, a data line and an enable, and they share pins with the straps and mode pins. Bits enter a 24-bit shift register, most significant bit first. A rising enable commits the low 22 bits to the word that the top two bits address. The divider values, band, VCO current, operating state, modulation selection and LNA gain selection come out as decoded fields. The raw words are also brought out for the remaining fields. All pins pass through two-flop synchronizers, and their edges are found in the system clock domain. A pin change therefore acts on the third rising clock edge after it is sampled.

Top module: `radio_cfg_bank`

## Requirements
- R1: At the third clock edge after reset release, the words load from straps sel={fs1,fs0}. Per sel, (rx/tx ref divider, rx fb divider, tx fb divider, band, vco) is: 0:(16,1919,1943,1,3), 1:(32,1894,1942,0,1), 2:(32,4047,4095,1,3), 3:(18,766,793,0,0). Word A = ref divider in [9:0] plus bit 13 set. Word B = ref divider in [9:0] plus bit 20 set. Word C = fb divider in [16:0], band in bit 17, vco in [19:18]. Word D = tx fb divider in [16:0]. Every other bit is zero.
- R2: In stand-alone mode opmode_o = {te,re}, encoded 0 standby, 1 receive, 2 transmit, 3 idle. Clock and data activity on these pins leaves all words unchanged.
- R3: The first level of the enable/strap pin that differs from the strapped level sets prog_mode_o. prog_mode_o then stays at 1 until reset. The transition that causes the switch writes no word.
- R4: In programmable mode, each rising serial clock shifts the data pin into a 24-bit register at bit 0, so the first bit sent ends in bit 23.
- R5: In programmable mode, a rising enable copies register bits 21:0 into the word that bits 23:22 select (0 A, 1 B, 2 C, 3 D). The other words are unchanged. Writes are accepted in every operating state, and the values are kept across standby.
- R6: When more than 24 bits are sent before the enable rises, only the last 24 take effect.
- R7: In programmable mode opmode_o = word A bits 11:10. Activity on the clock and data pins with no rising enable leaves it unchanged.
- R8: mod_fsk_o follows ext_fsk_i while word D bit 21 is 0, and follows word A bit 19 while it is 1.
- R9: lna_high_o is the inverse of ext_gain_low_i while word C bit 21 is 0, and follows word A bit 12 while it is 1.
- R10: All outputs match a reference model in which every pin acts with a latency of three clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| re_sclk_i | input | 1 | Receive-enable pin in stand-alone mode, serial clock in programmable mode |
| te_sdata_i | input | 1 | Transmit-enable pin in stand-alone mode, serial data in programmable mode |
| fs0_sen_i | input | 1 | Frequency strap bit 0, then serial enable |
| fs1_i | input | 1 | Frequency strap bit 1 |
| ext_fsk_i | input | 1 | External modulation pin (1 = FSK) |
| ext_gain_low_i | input | 1 | External LNA gain pin (1 = low gain) |
| prog_mode_o | output | 1 | Programmable mode entered |
| opmode_o | output | 2 | Operating state |
| mod_fsk_o | output | 1 | Selected modulation (1 = FSK) |
| lna_high_o | output | 1 | Selected LNA gain (1 = high) |
| rx_ref_div_o | output | 10 | Receive reference divider |
| tx_ref_div_o | output | 10 | Transmit reference divider |
| rx_fb_div_o | output | 17 | Receive feedback divider |
| tx_fb_div_o | output | 17 | Transmit feedback divider |
| band_o | output | 1 | Band select |
| vco_cur_o | output | 2 | VCO current setting |
| word_a_o | output | 22 | Raw word A |
| word_b_o | output | 22 | Raw word B |
| word_c_o | output | 22 | Raw word C |
| word_d_o | output | 22 | Raw word D |

## Verification
The assertions assume that the strap pins are stable from before reset release until the preset is captured. They also assume that the serial data pin is steady while the serial clock rises, and that a clock edge and an enable edge never reach the synchronizers in the same cycle. The stimulus holds every pin level for at least two clocks. It sets data three clocks before raising the serial clock, and it separates the last serial clock pulse from the enable pulse by several cycles, so each edge is seen alone after synchronization.

// File: rtl/rcb_pkg.sv
package rcb_pkg;
    localparam int WORD_W    = 22;
    localparam int ADDR_W    = 2;
    localparam int FRAME_W   = WORD_W + ADDR_W;
    localparam int NUM_WORDS = 1 << ADDR_W;
    localparam int REF_W     = 10;
    localparam int FB_W      = 17;

    localparam int IDX_A = 0;
    localparam int IDX_B = 1;
    localparam int IDX_C = 2;
    localparam int IDX_D = 3;

    localparam int A_OPMODE_LO = 10;
    localparam int A_GAIN_BIT  = 12;
    localparam int A_KEEP1_BIT = 13;
    localparam int A_MODSEL    = 19;
    localparam int B_KEEP1_BIT = 20;
    localparam int C_BAND_BIT  = 17;
    localparam int C_VCO_LO    = 18;
    localparam int C_GAINSRC   = 21;
    localparam int D_MODSRC    = 21;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_STANDBY = 2'd0,
        OP_RX      = 2'd1,
        OP_TX      = 2'd2,
        OP_IDLE    = 2'd3
    } opmode_e;

    typedef struct packed {
        logic [REF_W-1:0] ref_div;
        logic [FB_W-1:0]  rx_fb;
        logic [FB_W-1:0]  tx_fb;
        logic             band;
        logic [1:0]       vco;
    } preset_t;

    function automatic preset_t preset_for(input logic [1:0] sel);
        preset_t p;
        case (sel)
            2'd0:    p = '{ref_div: 10'd16, rx_fb: 17'd1919, tx_fb: 17'd1943, band: 1'b1, vco: 2'd3};
            2'd1:    p = '{ref_div: 10'd32, rx_fb: 17'd1894, tx_fb: 17'd1942, band: 1'b0, vco: 2'd1};
            2'd2:    p = '{ref_div: 10'd32, rx_fb: 17'd4047, tx_fb: 17'd4095, band: 1'b1, vco: 2'd3};
            default: p = '{ref_div: 10'd18, rx_fb: 17'd766,  tx_fb: 17'd793,  band: 1'b0, vco: 2'd0};
        endcase
        return p;
    endfunction

    function automatic word_t preset_word(input logic [ADDR_W-1:0] idx, input logic [1:0] sel);
        preset_t p;
        word_t   w;
        p = preset_for(sel);
        w = '0;
        case (idx)
            2'd0: begin
                w[REF_W-1:0]   = p.ref_div;
                w[A_KEEP1_BIT] = 1'b1;
            end
            2'd1: begin
                w[REF_W-1:0]   = p.ref_div;
                w[B_KEEP1_BIT] = 1'b1;
            end
            2'd2: begin
                w[FB_W-1:0]             = p.rx_fb;
                w[C_BAND_BIT]           = p.band;
                w[C_VCO_LO+1:C_VCO_LO]  = p.vco;
            end
            default: w[FB_W-1:0] = p.tx_fb;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/rcb_sync.sv
module rcb_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/rcb_shift.sv
module rcb_shift
    import rcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en_i,
    input  logic              bit_i,
    input  logic              commit_i,
    output logic              load_vld_o,
    output logic [ADDR_W-1:0] load_addr_o,
    output word_t             load_data_o
);
    typedef struct packed {
        logic [FRAME_W-1:0] frame;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (shift_en_i) begin
            sh_d.frame = {sh_q.frame[FRAME_W-2:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    // A commit uses the frame as it stood before any shift in the same cycle.
    assign load_vld_o  = commit_i;
    assign load_addr_o = sh_q.frame[FRAME_W-1:WORD_W];
    assign load_data_o = sh_q.frame[WORD_W-1:0];
endmodule

// File: rtl/rcb_words.sv
module rcb_words
    import rcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preset_en_i,
    input  logic [1:0]        preset_sel_i,
    input  logic              load_vld_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  word_t             load_data_i,
    output word_t             words_o [NUM_WORDS]
);
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        word_t w_d, w_q;

        always_comb begin
            w_d = w_q;
            if (preset_en_i) begin
                w_d = preset_word(ADDR_W'(g), preset_sel_i);
            end else if (load_vld_i && (load_addr_i == ADDR_W'(g))) begin
                w_d = load_data_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                w_q <= '0;
            end else begin
                w_q <= w_d;
            end
        end

        assign words_o[g] = w_q;
    end
endmodule

// File: rtl/radio_cfg_bank.sv
module radio_cfg_bank
    import rcb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        re_sclk_i,
    input  logic        te_sdata_i,
    input  logic        fs0_sen_i,
    input  logic        fs1_i,
    input  logic        ext_fsk_i,
    input  logic        ext_gain_low_i,
    output logic        prog_mode_o,
    output logic [1:0]  opmode_o,
    output logic        mod_fsk_o,
    output logic        lna_high_o,
    output logic [9:0]  rx_ref_div_o,
    output logic [9:0]  tx_ref_div_o,
    output logic [16:0] rx_fb_div_o,
    output logic [16:0] tx_fb_div_o,
    output logic        band_o,
    output logic [1:0]  vco_cur_o,
    output logic [21:0] word_a_o,
    output logic [21:0] word_b_o,
    output logic [21:0] word_c_o,
    output logic [21:0] word_d_o
);
    localparam int PIN_W = 4;
    localparam int P_RE  = 0;
    localparam int P_TE  = 1;
    localparam int P_FS0 = 2;
    localparam int P_FS1 = 3;
    localparam int CNT_W = $clog2(SYNC_STAGES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             init;
        logic             ref_fs0;
        logic             prog;
        logic [1:0]       pinmode;
        logic             prev_sclk;
        logic             prev_sen;
    } ctl_t;

    logic [PIN_W-1:0] pins_raw, pins_s;
    ctl_t             st_d, st_q;
    logic             preset_en;
    logic             sclk_rise, sen_rise;
    logic             shift_strobe, wr_strobe;
    logic             init_done;
    logic             load_vld;
    logic [ADDR_W-1:0] load_addr;
    word_t            load_data;
    word_t            words [NUM_WORDS];

    assign pins_raw = {fs1_i, fs0_sen_i, te_sdata_i, re_sclk_i};

    rcb_sync #(
        .WIDTH (PIN_W),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pins_raw),
        .sync_o (pins_s)
    );

    assign sclk_rise    = pins_s[P_RE]  & ~st_q.prev_sclk;
    assign sen_rise     = pins_s[P_FS0] & ~st_q.prev_sen;
    assign shift_strobe = st_q.prog & sclk_rise;
    assign wr_strobe    = st_q.prog & sen_rise;
    assign init_done    = st_q.init;

    always_comb begin
        st_d           = st_q;
        st_d.prev_sclk = pins_s[P_RE];
        st_d.prev_sen  = pins_s[P_FS0];
        st_d.pinmode   = {pins_s[P_TE], pins_s[P_RE]};
        preset_en      = 1'b0;
        if (!st_q.init) begin
            // wait until the synchronizers carry the first post-reset pin sample
            if (st_q.cnt < CNT_W'(SYNC_STAGES)) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end else begin
                st_d.init    = 1'b1;
                st_d.ref_fs0 = pins_s[P_FS0];
                preset_en    = 1'b1;
            end
        end else if (!st_q.prog && (pins_s[P_FS0] != st_q.ref_fs0)) begin
            st_d.prog = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    rcb_shift u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en_i (shift_strobe),
        .bit_i      (pins_s[P_TE]),
        .commit_i   (wr_strobe),
        .load_vld_o (load_vld),
        .load_addr_o(load_addr),
        .load_data_o(load_data)
    );

    rcb_words u_words (
        .clk         (clk),
        .rst_n       (rst_n),
        .preset_en_i (preset_en),
        .preset_sel_i({pins_s[P_FS1], pins_s[P_FS0]}),
        .load_vld_i  (load_vld),
        .load_addr_i (load_addr),
        .load_data_i (load_data),
        .words_o     (words)
    );

    assign prog_mode_o  = st_q.prog;
    assign opmode_o     = st_q.prog ? words[IDX_A][A_OPMODE_LO+1:A_OPMODE_LO] : st_q.pinmode;
    assign mod_fsk_o    = words[IDX_D][D_MODSRC]  ? words[IDX_A][A_MODSEL]   : ext_fsk_i;
    assign lna_high_o   = words[IDX_C][C_GAINSRC] ? words[IDX_A][A_GAIN_BIT] : ~ext_gain_low_i;
    assign rx_ref_div_o = words[IDX_A][REF_W-1:0];
    assign tx_ref_div_o = words[IDX_B][REF_W-1:0];
    assign rx_fb_div_o  = words[IDX_C][FB_W-1:0];
    assign tx_fb_div_o  = words[IDX_D][FB_W-1:0];
    assign band_o       = words[IDX_C][C_BAND_BIT];
    assign vco_cur_o    = words[IDX_C][C_VCO_LO+1:C_VCO_LO];
    assign word_a_o     = words[IDX_A];
    assign word_b_o     = words[IDX_B];
    assign word_c_o     = words[IDX_C];
    assign word_d_o     = words[IDX_D];
endmodule

// File: rtl/rcb_checks.sv
module rcb_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        prog,
    input logic [1:0]  opmode,
    input logic        init_done,
    input logic        wr_strobe,
    input logic [21:0] word_a,
    input logic [21:0] word_b,
    input logic [21:0] word_c,
    input logic [21:0] word_d,
    input logic [9:0]  rx_ref,
    input logic [9:0]  tx_ref
);
    a_r3_prog_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        prog |=> prog);

    a_r2_standalone_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(init_done) && !$past(prog)) |->
            ($stable(word_a) && $stable(word_b) && $stable(word_c) && $stable(word_d)));

    a_r5_write_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(init_done) && !$past(wr_strobe)) |->
            ($stable(word_a) && $stable(word_b) && $stable(word_c) && $stable(word_d)));

    a_r7_opmode_tracks_word_a: assert property (@(posedge clk) disable iff (!rst_n)
        (prog && $past(prog) && $stable(word_a)) |-> $stable(opmode));

    a_r1_preset_divider: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> ((rx_ref == 10'd16 || rx_ref == 10'd18 || rx_ref == 10'd32)
                              && tx_ref == rx_ref));
endmodule

bind radio_cfg_bank rcb_checks u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog     (prog_mode_o),
    .opmode   (opmode_o),
    .init_done(init_done),
    .wr_strobe(wr_strobe),
    .word_a   (word_a_o),
    .word_b   (word_b_o),
    .word_c   (word_c_o),
    .word_d   (word_d_o),
    .rx_ref   (rx_ref_div_o),
    .tx_ref   (tx_ref_div_o)
);

// File: tb/radio_cfg_bank_bench.sv
`timescale 1ns/1ps
module radio_cfg_bank_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic re = 1'b0, te = 1'b0, fs0 = 1'b0, fs1 = 1'b0;
    logic ext_fsk = 1'b0, ext_gain = 1'b0;

    logic        prog_mode;
    logic [1:0]  opmode;
    logic        mod_fsk, lna_high, band;
    logic [9:0]  rx_ref, tx_ref;
    logic [16:0] rx_fb, tx_fb;
    logic [1:0]  vco;
    logic [21:0] wa, wb, wc, wd;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    bit started = 1'b0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    radio_cfg_bank u_radio_cfg_bank (
        .clk(clk), .rst_n(rst_n),
        .re_sclk_i(re), .te_sdata_i(te), .fs0_sen_i(fs0), .fs1_i(fs1),
        .ext_fsk_i(ext_fsk), .ext_gain_low_i(ext_gain),
        .prog_mode_o(prog_mode), .opmode_o(opmode),
        .mod_fsk_o(mod_fsk), .lna_high_o(lna_high),
        .rx_ref_div_o(rx_ref), .tx_ref_div_o(tx_ref),
        .rx_fb_div_o(rx_fb), .tx_fb_div_o(tx_fb),
        .band_o(band), .vco_cur_o(vco),
        .word_a_o(wa), .word_b_o(wb), .word_c_o(wc), .word_d_o(wd)
    );

    // preset table from R1, indexed by {fs1,fs0}
    int t_ref [4] = '{16, 32, 32, 18};
    int t_nr  [4] = '{1919, 1894, 4047, 766};
    int t_nt  [4] = '{1943, 1942, 4095, 793};
    int t_band[4] = '{1, 0, 1, 0};
    int t_vco [4] = '{3, 1, 3, 0};

    function automatic logic [21:0] exp_preset(input int idx, input int sel);
        case (idx)
            0: return 22'(t_ref[sel]) | 22'h002000;
            1: return 22'(t_ref[sel]) | 22'h100000;
            2: return 22'(t_nr[sel]) | 22'(t_band[sel] << 17) | 22'(t_vco[sel] << 18);
            default: return 22'(t_nt[sel]);
        endcase
    endfunction

    // reference model: pins act three edges after they are sampled (R10)
    logic [3:0]  hist [$];
    int          m_wait;
    bit          m_init, m_ref, m_prog;
    logic [1:0]  m_pm;
    logic [23:0] m_sh;
    logic [21:0] m_w [4];

    always @(posedge clk) begin
        logic [3:0] cur, prv;
        if (!rst_n) begin
            hist = {4'b0, 4'b0, 4'b0};
            m_wait = 0; m_init = 0; m_ref = 0; m_prog = 0; m_pm = 2'b0; m_sh = '0;
            for (int i = 0; i < 4; i++) m_w[i] = '0;
        end else begin
            hist.push_front({fs1, fs0, te, re});
            cur = hist[2];
            prv = hist[3];
            void'(hist.pop_back());
            m_pm = {cur[1], cur[0]};
            if (!m_init) begin
                if (m_wait < 2) m_wait++;
                else begin
                    m_init = 1;
                    m_ref = cur[2];
                    for (int i = 0; i < 4; i++) m_w[i] = exp_preset(i, int'({cur[3], cur[2]}));
                end
            end else if (!m_prog) begin
                if (cur[2] != m_ref) m_prog = 1;
            end else begin
                if (cur[2] && !prv[2]) m_w[m_sh[23:22]] = m_sh[21:0];
                if (cur[0] && !prv[0]) m_sh = {m_sh[22:0], cur[1]};
            end
        end
        started = 1'b1;
    end

    always @(negedge clk) begin
        logic [1:0] e_op;
        logic e_mod, e_lna;
        if (started && !finished) begin
            e_op  = m_prog ? m_w[0][11:10] : m_pm;
            e_mod = m_w[3][21] ? m_w[0][19] : ext_fsk;
            e_lna = m_w[2][21] ? m_w[0][12] : ~ext_gain;
            checks++;
            if ({wa, wb, wc, wd} !== {m_w[0], m_w[1], m_w[2], m_w[3]} ||
                {prog_mode, opmode, mod_fsk, lna_high} !== {m_prog, e_op, e_mod, e_lna}) begin
                failures++;
                $display("FAIL %s/R10 model: act words=%h %h %h %h pm=%b op=%0d mod=%b lna=%b exp words=%h %h %h %h pm=%b op=%0d mod=%b lna=%b",
                         phase, wa, wb, wc, wd, prog_mode, opmode, mod_fsk, lna_high,
                         m_w[0], m_w[1], m_w[2], m_w[3], m_prog, e_op, e_mod, e_lna);
            end
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic s1, input logic s0);
        rst_n = 1'b0; re = 0; te = 0; fs1 = s1; fs0 = s0;
        clks(3);
        rst_n = 1'b1;
        clks(6);
    endtask

    task automatic send_bits(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            te = bits[i];
            clks(3);
            re = 1'b1;
            clks(3);
            re = 1'b0;
            clks(2);
        end
        clks(3);
        fs0 = 1'b1;
        clks(4);
        fs0 = 1'b0;
        clks(4);
    endtask

    initial begin
        logic [21:0] a_val;
        // R1: every preset
        for (int s = 0; s < 4; s++) begin
            phase = "R1";
            do_reset(s[1], s[0]);
            check("R1", "rx_ref", 32'(rx_ref), 32'(t_ref[s]));
            check("R1", "tx_ref", 32'(tx_ref), 32'(t_ref[s]));
            check("R1", "rx_fb",  32'(rx_fb),  32'(t_nr[s]));
            check("R1", "tx_fb",  32'(tx_fb),  32'(t_nt[s]));
            check("R1", "band",   32'(band),   32'(t_band[s]));
            check("R1", "vco",    32'(vco),    32'(t_vco[s]));
            check("R1", "word_a", 32'(wa), 32'(exp_preset(0, s)));
            check("R1", "word_b", 32'(wb), 32'(exp_preset(1, s)));
            check("R3", "prog after reset", 32'(prog_mode), 32'd0);
        end
        // R2: stand-alone mode pins, last reset used straps 11
        phase = "R2";
        re = 1; te = 0; clks(4);
        check("R2", "opmode rx", 32'(opmode), 32'd1);
        re = 0; te = 1; clks(4);
        check("R2", "opmode tx", 32'(opmode), 32'd2);
        re = 1; te = 1; clks(4);
        check("R2", "opmode idle", 32'(opmode), 32'd3);
        for (int i = 0; i < 6; i++) begin
            re = ~re; clks(3); te = ~te; clks(3);
        end
        re = 0; te = 0; clks(4);
        check("R2", "opmode standby", 32'(opmode), 32'd0);
        check("R2", "word_c kept", 32'(wc), 32'(exp_preset(2, 3)));
        check("R2", "word_a kept", 32'(wa), 32'(exp_preset(0, 3)));
        // R8 / R9: external pins in effect
        ext_fsk = 1; ext_gain = 1; clks(1);
        check("R8", "mod from pin", 32'(mod_fsk), 32'd1);
        check("R9", "gain from pin", 32'(lna_high), 32'd0);
        ext_fsk = 0; ext_gain = 0; clks(1);
        check("R8", "mod from pin low", 32'(mod_fsk), 32'd0);
        check("R9", "gain from pin high", 32'(lna_high), 32'd1);

        // R3: strap fs0=1 then first falling level enters programmable mode
        do_reset(1'b0, 1'b1);
        phase = "R3";
        fs0 = 1'b0; clks(5);
        check("R3", "prog entered", 32'(prog_mode), 32'd1);
        check("R3", "no write on switch", 32'(wa), 32'(exp_preset(0, 1)));
        // R4/R5/R7: write A: modsel=1, gain=1, opmode=tx, rr=100
        phase = "R5";
        a_val = 22'((1 << 19) | (1 << 12) | (2 << 10) | 100);
        send_bits({8'h0, 2'b00, a_val}, 24);
        check("R5", "word_a written", 32'(wa), 32'(a_val));
        check("R7", "opmode from word A", 32'(opmode), 32'd2);
        check("R5", "word_b untouched", 32'(wb), 32'(exp_preset(1, 1)));
        // R7: pin activity without enable
        phase = "R7";
        for (int i = 0; i < 4; i++) begin
            te = ~te; clks(3); re = 1; clks(3); re = 0; clks(3);
        end
        te = 0; clks(4);
        check("R7", "opmode held", 32'(opmode), 32'd2);
        check("R7", "word_a held", 32'(wa), 32'(a_val));
        // R5: standby then write B, values kept
        phase = "R5";
        send_bits({8'h0, 2'b00, 22'(100)}, 24);
        check("R5", "opmode standby", 32'(opmode), 32'd0);
        send_bits({8'h0, 2'b01, 22'h100000 | 22'd200}, 24);
        check("R5", "word_b written in standby", 32'(tx_ref), 32'd200);
        check("R5", "word_a kept", 32'(wa), 32'd100);
        send_bits({8'h0, 2'b00, a_val}, 24);
        // R9: write C with internal gain control
        phase = "R9";
        send_bits({8'h0, 2'b10, 22'((1 << 21) | (2 << 18) | (1 << 17) | 5000)}, 24);
        ext_gain = 1; clks(1);
        check("R9", "gain from word A", 32'(lna_high), 32'd1);
        check("R4", "rx_fb shifted msb first", 32'(rx_fb), 32'd5000);
        check("R4", "vco field", 32'(vco), 32'd2);
        // R6 / R8: 26-bit frame to D with internal modulation control
        phase = "R6";
        send_bits({6'h0, 2'b10, 2'b11, 22'((1 << 21) | (3 << 19) | 777)}, 26);
        check("R6", "tx_fb from last 24 bits", 32'(tx_fb), 32'd777);
        check("R6", "word_d", 32'(wd), 32'((1 << 21) | (3 << 19) | 777));
        check("R6", "word_b untouched", 32'(tx_ref), 32'd200);
        ext_fsk = 0; clks(1);
        check("R8", "mod from word A", 32'(mod_fsk), 32'd1);
        check("R3", "still programmable", 32'(prog_mode), 32'd1);

        // R3: strap fs0=0, rising level enters without write
        do_reset(1'b1, 1'b0);
        phase = "R3";
        fs0 = 1'b1; clks(5);
        check("R3", "prog on rise", 32'(prog_mode), 32'd1);
        check("R3", "word_a preset kept", 32'(wa), 32'(exp_preset(0, 2)));
        check("R3", "word_d preset kept", 32'(wd), 32'(exp_preset(3, 2)));
        fs0 = 1'b0; clks(4);
        send_bits({8'h0, 2'b11, 22'd64}, 24);
        check("R5", "word_d after strap-0 entry", 32'(tx_fb), 32'd64);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule